// File: doc/BRIEF.md
# Remote Line Cache Controller

This block caches memory lines for one node of a coherent system of up to eight nodes. It keeps only lines whose home memory controller sits on another node. It watches three streams: requests from local processors, read responses coming back through the node bridge, and modified-line writebacks from local processors. A read response that answers a plain read installs the line, and so does a writeback of a remote-home line. After that, a local read of the line is answered here, one cycle later, and the request never leaves the node. Any request this cache does not answer goes out on the forward port unchanged, and so does any request for a line whose home is this node.

A directory probe port lets a remote directory remove a line. The probe is always acknowledged on the following cycle, whether or not it hit. A fill is stored as Exclusive only when the directory-present input is high. When it is low, every fill is stored as Shared. The array has a parameterised number of sets and ways. A fill takes the lowest invalid way of its set first; when the set is full, a per-set round-robin pointer picks the way to evict. Clean lines need no writeback on eviction.

Top module: `rdc_ctrl`

## Requirements
- R1: A request, read response or writeback whose home node equals `node_id` never installs a line. Such a request appears on the forward port one cycle later with the same address and modify flag, and it is never answered locally.
- R2: A read response installs its line when `rr_modify` is 0. When `rr_modify` is 1, nothing is installed.
- R3: A writeback of a line with a remote home installs the line together with its data.
- R4: A local read (`req_modify`=0) that hits raises `rsp_valid` one cycle later with the stored data, and `fwd_valid` stays low. A read that misses raises `fwd_valid` one cycle later with the same address.
- R5: A fill is stored as Exclusive (`rsp_excl`=1) if `cfg_dir_present` is 1 at fill time. Otherwise it is stored as Shared (`rsp_excl`=0). A refill of a line that is already present updates both its data and its state.
- R6: The home node is address bits [ADDR_W-1:ADDR_W-3], which are [15:13] by default. The set index is address bits [IDX_W-1:0].
- R7: A request-to-modify (`req_modify`=1) that hits invalidates the line and is forwarded one cycle later with `fwd_modify`=1. No local response is given.
- R8: A fill that misses takes the lowest-numbered invalid way of its set. When every way of the set is valid, the fill takes the way named by that set's round-robin pointer, and the pointer moves to the next way, wrapping to 0. A fill into a free way leaves the pointer unchanged.
- R9: An invalidate probe clears the matching line and raises `inv_ack` for exactly the next cycle, also when the probe misses.
- R10: Only one event is taken per cycle, in the priority order probe, read response, writeback, local request. A lower-priority event offered in the same cycle is dropped with no effect.
- R11: After reset every line is invalid and `rsp_valid`, `fwd_valid` and `inv_ack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_id | input | 3 | Number of this node |
| cfg_dir_present | input | 1 | Directory present; allows the Exclusive state |
| req_valid | input | 1 | Local request strobe |
| req_addr | input | ADDR_W | Local request line address |
| req_modify | input | 1 | Local request is a request-to-modify |
| rsp_valid | output | 1 | Local hit response strobe |
| rsp_data | output | DATA_W | Data for the hit response |
| rsp_excl | output | 1 | State of the line that hit (1 Exclusive, 0 Shared) |
| fwd_valid | output | 1 | Request passed onward |
| fwd_addr | output | ADDR_W | Address of the passed request |
| fwd_modify | output | 1 | Modify flag of the passed request |
| rr_valid | input | 1 | Snooped read response strobe |
| rr_addr | input | ADDR_W | Read response line address |
| rr_modify | input | 1 | The original request was a request-to-modify |
| rr_data | input | DATA_W | Read response data |
| wb_valid | input | 1 | Local victim writeback strobe |
| wb_addr | input | ADDR_W | Writeback line address |
| wb_data | input | DATA_W | Writeback data |
| inv_valid | input | 1 | Directory invalidate probe strobe |
| inv_addr | input | ADDR_W | Probe line address |
| inv_ack | output | 1 | Probe acknowledge |

## Verification
A sweep covers all 64 pairings of local node number and home field. In each pairing, a line is written back, read, then probed. This separates remote homes, where the read must hit with the written data, from the local home, where the read must be forwarded unchanged. The bench also fills lines from read responses with and without the modify flag, and with the directory input both high and low. These runs tell a Shared fill apart from an Exclusive fill and from a response that installs nothing. A sequence of fills into one set separates free-way-first allocation from pointer-driven eviction. Further runs issue a request-to-modify against a cached line, and offer events in the same cycle to show which one wins.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

    localparam int NODE_W = 3;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_INV,
        EV_FILL,
        EV_REQ
    } ev_e;

endpackage

// File: rtl/rdc_store.sv
module rdc_store #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 14,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [WAYS-1:0]              rd_valid,
    output logic [WAYS-1:0]              rd_excl,
    output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                         we,
    input  logic [IDX_W-1:0]             w_idx,
    input  logic [WAY_W-1:0]             w_way,
    input  logic                         w_valid,
    input  logic                         w_excl,
    input  logic [TAG_W-1:0]             w_tag,
    input  logic [DATA_W-1:0]            w_data
);

    typedef struct packed {
        logic              valid;
        logic              excl;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t [SETS-1:0][WAYS-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (we) begin
            ent_d[w_idx][w_way].valid = w_valid;
            ent_d[w_idx][w_way].excl  = w_excl;
            ent_d[w_idx][w_way].tag   = w_tag;
            ent_d[w_idx][w_way].data  = w_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_valid[w] = ent_q[rd_idx][w].valid;
        assign rd_excl[w]  = ent_q[rd_idx][w].excl;
        assign rd_tag[w]   = ent_q[rd_idx][w].tag;
        assign rd_data[w]  = ent_q[rd_idx][w].data;
    end

endmodule

// File: rtl/rdc_lookup.sv
module rdc_lookup #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 14,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           tag,
    output logic [WAYS-1:0]            match,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       free,
    output logic [WAY_W-1:0]           free_way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tag[w] == tag);
    end

    always_comb begin
        hit      = |match;
        free     = ~&way_valid;
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])      hit_way  = WAY_W'(w);
            if (!way_valid[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/rdc_victim.sv
module rdc_victim #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_ptr,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_idx
);

    logic [SETS-1:0][WAY_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) begin
            if (ptr_q[adv_idx] == WAY_W'(WAYS - 1)) ptr_d[adv_idx] = '0;
            else                                    ptr_d[adv_idx] = ptr_q[adv_idx] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign rd_ptr = ptr_q[rd_idx];

endmodule

// File: rtl/rdc_ctrl.sv
module rdc_ctrl
    import rdc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    localparam int IDX_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - IDX_W,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int HOME_LSB = ADDR_W - NODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NODE_W-1:0] node_id,
    input  logic              cfg_dir_present,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_modify,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_excl,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic              fwd_modify,
    input  logic              rr_valid,
    input  logic [ADDR_W-1:0] rr_addr,
    input  logic              rr_modify,
    input  logic [DATA_W-1:0] rr_data,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_ack
);

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_excl;
        logic              fwd_valid;
        logic [ADDR_W-1:0] fwd_addr;
        logic              fwd_modify;
        logic              inv_ack;
    } out_t;

    out_t out_d, out_q;

    // event selection, fixed priority (R10)
    ev_e               ev;
    logic [ADDR_W-1:0] sel_addr;
    logic [DATA_W-1:0] sel_data;
    logic              sel_modify;

    always_comb begin
        ev         = EV_NONE;
        sel_addr   = req_addr;
        sel_data   = '0;
        sel_modify = req_modify;
        if (inv_valid) begin
            ev       = EV_INV;
            sel_addr = inv_addr;
        end else if (rr_valid) begin
            ev       = rr_modify ? EV_NONE : EV_FILL;
            sel_addr = rr_addr;
            sel_data = rr_data;
        end else if (wb_valid) begin
            ev       = EV_FILL;
            sel_addr = wb_addr;
            sel_data = wb_data;
        end else if (req_valid) begin
            ev = EV_REQ;
        end
    end

    logic [NODE_W-1:0] sel_home;
    logic              sel_remote;
    logic [IDX_W-1:0]  sel_idx;
    logic [TAG_W-1:0]  sel_tag;

    assign sel_home   = sel_addr[HOME_LSB +: NODE_W];
    assign sel_remote = (sel_home != node_id);
    assign sel_idx    = sel_addr[IDX_W-1:0];
    assign sel_tag    = sel_addr[ADDR_W-1:IDX_W];

    // array, lookup and replacement
    logic [WAYS-1:0]             way_valid, way_excl, match;
    logic [WAYS-1:0][TAG_W-1:0]  way_tag;
    logic [WAYS-1:0][DATA_W-1:0] way_data;
    logic                        hit, free;
    logic [WAY_W-1:0]            hit_way, free_way, rr_ptr;

    logic             we, w_valid, w_excl, adv;
    logic [WAY_W-1:0] w_way;

    rdc_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(sel_idx),
        .rd_valid(way_valid), .rd_excl(way_excl),
        .rd_tag(way_tag), .rd_data(way_data),
        .we(we), .w_idx(sel_idx), .w_way(w_way),
        .w_valid(w_valid), .w_excl(w_excl),
        .w_tag(sel_tag), .w_data(sel_data)
    );

    rdc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .way_valid(way_valid), .way_tag(way_tag), .tag(sel_tag),
        .match(match), .hit(hit), .hit_way(hit_way),
        .free(free), .free_way(free_way)
    );

    rdc_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(sel_idx), .rd_ptr(rr_ptr),
        .adv(adv), .adv_idx(sel_idx)
    );

    always_comb begin
        out_d            = out_q;
        out_d.rsp_valid  = 1'b0;
        out_d.fwd_valid  = 1'b0;
        out_d.inv_ack    = 1'b0;
        we      = 1'b0;
        w_valid = 1'b0;
        w_excl  = 1'b0;
        w_way   = hit_way;
        adv     = 1'b0;
        case (ev)
            EV_INV: begin
                out_d.inv_ack = 1'b1;
                we            = hit;
            end
            EV_FILL: begin
                if (sel_remote) begin
                    we      = 1'b1;
                    w_valid = 1'b1;
                    w_excl  = cfg_dir_present;
                    if (hit)       w_way = hit_way;
                    else if (free) w_way = free_way;
                    else begin
                        w_way = rr_ptr;
                        adv   = 1'b1;
                    end
                end
            end
            EV_REQ: begin
                if (sel_remote && hit && !sel_modify) begin
                    out_d.rsp_valid = 1'b1;
                    out_d.rsp_data  = way_data[hit_way];
                    out_d.rsp_excl  = way_excl[hit_way];
                end else begin
                    out_d.fwd_valid  = 1'b1;
                    out_d.fwd_addr   = sel_addr;
                    out_d.fwd_modify = sel_modify;
                    we               = sel_remote && hit;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid  = out_q.rsp_valid;
    assign rsp_data   = out_q.rsp_data;
    assign rsp_excl   = out_q.rsp_excl;
    assign fwd_valid  = out_q.fwd_valid;
    assign fwd_addr   = out_q.fwd_addr;
    assign fwd_modify = out_q.fwd_modify;
    assign inv_ack    = out_q.inv_ack;

    // sticky record that a directory was ever reported, for the state check
    logic dir_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               dir_seen_q <= 1'b0;
        else if (cfg_dir_present) dir_seen_q <= 1'b1;
    end

    assert_local_never_served_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(sel_home) != $past(node_id)));

    assert_modify_no_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_valid && rr_modify && !inv_valid) |-> !w_valid);

    assert_hit_not_forwarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && fwd_valid));

    assert_excl_needs_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_excl) |-> dir_seen_q);

    assert_modify_hit_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_REQ && sel_remote && hit && sel_modify) |=> (fwd_valid && fwd_modify && !rsp_valid));

    assert_single_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    assert_probe_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> inv_ack);

    assert_ack_only_after_probe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> !inv_ack);

endmodule

// File: tb/rdc_ctrl_tb.sv
module rdc_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  node_id = 3'd0;
    logic        cfg_dir_present = 1'b0;
    logic        req_valid = 1'b0, req_modify = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rsp_valid, rsp_excl, fwd_valid, fwd_modify, inv_ack;
    logic [31:0] rsp_data;
    logic [15:0] fwd_addr;
    logic        rr_valid = 1'b0, rr_modify = 1'b0;
    logic [15:0] rr_addr = '0;
    logic [31:0] rr_data = '0;
    logic        wb_valid = 1'b0;
    logic [15:0] wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic        inv_valid = 1'b0;
    logic [15:0] inv_addr = '0;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rdc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .cfg_dir_present(cfg_dir_present),
        .req_valid(req_valid), .req_addr(req_addr), .req_modify(req_modify),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_excl(rsp_excl),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_modify(fwd_modify),
        .rr_valid(rr_valid), .rr_addr(rr_addr), .rr_modify(rr_modify), .rr_data(rr_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack)
    );

    function automatic logic [15:0] mk(input int h, input int t, input int idx);
        return {3'(h), 11'(t), 2'(idx)};
    endfunction

    function automatic logic [31:0] dat(input logic [15:0] a, input int salt);
        return {a, ~a ^ 16'(salt)};
    endfunction

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic do_wb(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wb_valid = 1'b1; wb_addr = a; wb_data = d;
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic do_rr(input logic [15:0] a, input logic [31:0] d, input logic m);
        @(negedge clk);
        rr_valid = 1'b1; rr_addr = a; rr_data = d; rr_modify = m;
        @(negedge clk);
        rr_valid = 1'b0;
    endtask

    task automatic do_inv(input logic [15:0] a, input string r);
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
        chk(inv_ack == 1'b1, r, 64'(inv_ack), 64'd1);
        @(negedge clk);
        chk(inv_ack == 1'b0, r, 64'(inv_ack), 64'd0);
    endtask

    task automatic do_req(input logic [15:0] a, input logic m, input bit exp_hit,
                          input logic [31:0] ed, input logic ex, input string r);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_modify = m;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk(rsp_valid && !fwd_valid, r, 64'({rsp_valid, fwd_valid}), 64'b10);
            chk(rsp_data == ed, r, 64'(rsp_data), 64'(ed));
            chk(rsp_excl == ex, r, 64'(rsp_excl), 64'(ex));
        end else begin
            chk(!rsp_valid && fwd_valid, r, 64'({rsp_valid, fwd_valid}), 64'b01);
            chk(fwd_addr == a && fwd_modify == m, r, 64'({fwd_addr, fwd_modify}), 64'({a, m}));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(!rsp_valid && !fwd_valid && !inv_ack, "R11", 64'({rsp_valid, fwd_valid, inv_ack}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !fwd_valid && !inv_ack, "R11", 64'({rsp_valid, fwd_valid, inv_ack}), 64'd0);
        do_req(mk(3, 5, 0), 1'b0, 0, '0, 1'b0, "R11 empty");

        // R1 / R6 / R3 / R4 / R9: sweep node number against home field
        for (int n = 0; n < 8; n++) begin
            node_id = 3'(n);
            for (int h = 0; h < 8; h++) begin
                logic [15:0] a;
                a = mk(h, n * 8 + h + 1, (n + h) % 4);
                do_wb(a, dat(a, n));
                do_req(a, 1'b0, h != n, dat(a, n), 1'b0, (h != n) ? "R3 R4 R6" : "R1 R6");
                do_inv(a, "R9");
            end
        end

        node_id = 3'd2;
        // R9: probe clears the line
        do_wb(mk(5, 100, 1), 32'h1111_2222);
        do_inv(mk(5, 100, 1), "R9");
        do_req(mk(5, 100, 1), 1'b0, 0, '0, 1'b0, "R9 cleared");

        // R1: local request-to-modify passes unchanged
        do_req(mk(2, 101, 3), 1'b1, 0, '0, 1'b0, "R1 modify");

        // R2 / R5: read response fills
        do_rr(mk(6, 200, 2), 32'hABCD_0001, 1'b0);
        do_req(mk(6, 200, 2), 1'b0, 1, 32'hABCD_0001, 1'b0, "R2 R5 shared");
        do_rr(mk(6, 201, 2), 32'hABCD_0002, 1'b1);
        do_req(mk(6, 201, 2), 1'b0, 0, '0, 1'b0, "R2 modify no fill");
        cfg_dir_present = 1'b1;
        do_rr(mk(7, 202, 0), 32'hABCD_0003, 1'b0);
        do_req(mk(7, 202, 0), 1'b0, 1, 32'hABCD_0003, 1'b1, "R2 R5 excl");
        do_wb(mk(7, 202, 0), 32'hABCD_0004);
        do_req(mk(7, 202, 0), 1'b0, 1, 32'hABCD_0004, 1'b1, "R3 R5 refill");
        cfg_dir_present = 1'b0;
        do_rr(mk(7, 202, 0), 32'hABCD_0005, 1'b0);
        do_req(mk(7, 202, 0), 1'b0, 1, 32'hABCD_0005, 1'b0, "R5 refill shared");
        do_rr(mk(2, 203, 0), 32'hABCD_0006, 1'b0);
        do_req(mk(2, 203, 0), 1'b0, 0, '0, 1'b0, "R1 rr local");
        do_inv(mk(6, 200, 2), "R9");
        do_inv(mk(7, 202, 0), "R9");

        // R7: request-to-modify hit invalidates and forwards
        do_wb(mk(4, 300, 3), 32'h7777_0000);
        do_req(mk(4, 300, 3), 1'b1, 0, '0, 1'b0, "R7 forward");
        do_req(mk(4, 300, 3), 1'b0, 0, '0, 1'b0, "R7 invalidated");

        // R8: replacement in set 1
        do_wb(mk(1, 400, 1), dat(mk(1, 400, 1), 1));
        do_wb(mk(1, 401, 1), dat(mk(1, 401, 1), 1));
        do_wb(mk(1, 402, 1), dat(mk(1, 402, 1), 1));
        do_req(mk(1, 400, 1), 1'b0, 0, '0, 1'b0, "R8 way0 evicted");
        do_req(mk(1, 401, 1), 1'b0, 1, dat(mk(1, 401, 1), 1), 1'b0, "R8 way1 kept");
        do_req(mk(1, 402, 1), 1'b0, 1, dat(mk(1, 402, 1), 1), 1'b0, "R8 new line");
        do_wb(mk(1, 403, 1), dat(mk(1, 403, 1), 1));
        do_req(mk(1, 401, 1), 1'b0, 0, '0, 1'b0, "R8 way1 evicted");
        do_req(mk(1, 402, 1), 1'b0, 1, dat(mk(1, 402, 1), 1), 1'b0, "R8 way0 kept");
        do_inv(mk(1, 402, 1), "R9");
        do_wb(mk(1, 404, 1), dat(mk(1, 404, 1), 1));
        do_req(mk(1, 403, 1), 1'b0, 1, dat(mk(1, 403, 1), 1), 1'b0, "R8 free way first");
        do_wb(mk(1, 405, 1), dat(mk(1, 405, 1), 1));
        do_req(mk(1, 404, 1), 1'b0, 0, '0, 1'b0, "R8 pointer unchanged by free fill");
        do_req(mk(1, 403, 1), 1'b0, 1, dat(mk(1, 403, 1), 1), 1'b0, "R8 other way kept");

        // R10: probe beats writeback in the same cycle
        @(negedge clk);
        inv_valid = 1'b1; inv_addr = mk(3, 500, 2);
        wb_valid = 1'b1; wb_addr = mk(3, 500, 2); wb_data = 32'h5A5A_5A5A;
        @(negedge clk);
        inv_valid = 1'b0; wb_valid = 1'b0;
        chk(inv_ack == 1'b1, "R10 probe taken", 64'(inv_ack), 64'd1);
        do_req(mk(3, 500, 2), 1'b0, 0, '0, 1'b0, "R10 writeback dropped");
        // R10: writeback beats local request
        @(negedge clk);
        wb_valid = 1'b1; wb_addr = mk(3, 501, 2); wb_data = 32'h6B6B_6B6B;
        req_valid = 1'b1; req_addr = mk(2, 502, 0); req_modify = 1'b0;
        @(negedge clk);
        wb_valid = 1'b0; req_valid = 1'b0;
        chk(!fwd_valid && !rsp_valid, "R10 request dropped", 64'({fwd_valid, rsp_valid}), 64'd0);
        do_req(mk(3, 501, 2), 1'b0, 1, 32'h6B6B_6B6B, 1'b0, "R10 writeback taken");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule